// File: doc/BRIEF.md
# Fuse Array Access Controller

This block sits on a 32-bit register bus in front of a one-time-programmable fuse store of 1024 bytes. Software fetches one stored byte into a data register with a read command, or burns a single addressed bit with a two-write unlock sequence. A fuse can only go from 0 to 1. A status word reports a done flag, which the host clears by writing a 1 to it.

A read-only strap word comes from three copies of a 32-bit word held in the first twelve bytes of the store. Each bit of the strap word is the 2-of-3 vote across those copies, so a single bad copy is outvoted. The fuse store is held in flip-flops inside the block and is cleared by reset, as on an unprogrammed part. A configuration word is kept here as plain storage. Any lock policy applied to it lives in a neighbouring block.

The bus takes one request per cycle. A read returns its data one cycle after the request, marked by a valid strobe. A write takes effect at the clock edge where it is sampled.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, status (word offset 0x00) reads 0x00000001, configuration (0x0C) reads 0x20000000, and address (0x04), data (0x08), strap (0x10) and command (0x14) read 0.
- R2: A read request returns its data on `bus_rdata` with `bus_rvalid` high in the next cycle, and `bus_rvalid` is low in every other cycle. An offset not listed in R1, or an address whose two low bits are not zero, reads 0.
- R3: Status bit 0 (ready) always reads 1. Bit 1 (done) is cleared only by writing status with bit 1 set; writing 0 there leaves it. Bit 2 (interrupt enable) stores the written value. Bits 31:3 read 0.
- R4: The address register stores write bits 12:0. Bits 9:0 select the byte and bits 12:10 select the bit within that byte. Bits 31:13 read 0.
- R5: Writing 0x00000002 to the command register loads the addressed byte into data bits 7:0, with the upper data bits 0, and sets done.
- R6: Writing 0xBF79E5D0 to the command register when the previous command write was 0x00000001 sets the addressed bit and sets done. Writes to other registers in between do not break the unlock, and the address used is the one held at the time of the second write.
- R7: If the previous command write was not 0x00000001, writing 0xBF79E5D0 changes no fuse and leaves done as it was. Any command value other than 0x00000001 cancels a pending unlock.
- R8: Programming never clears a fuse. Other bits of the byte keep their value, and programming a bit that is already set leaves the byte unchanged.
- R9: Writing 0x00000001 to the data register clears it to 0. A write of any other value leaves it unchanged.
- R10: Strap bit i is the majority of bit i of three little-endian words taken from bytes 0-3, 4-7 and 8-11. Writes to the strap offset change nothing.
- R11: The configuration register stores any written 32-bit value and reads it back.
- R12: Writes to unmapped or unaligned addresses change no register and no fuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address inside the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High in the cycle after a read request |

## Verification
Fuse state can only be seen through a read command followed by a data read, or through the strap word. A fuse that is set wrongly, or cleared, therefore shows up two bus accesses after the command that caused it, or at the next read of the strap word. A wrong unlock flag appears at once as a missing or extra done flag in the next status read, and as a changed byte in the following readback. The bench keeps its own model of the fuses, the flags and the unlock state, and compares every read response and every valid strobe against that model.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  // address register fields (position decoded by the store)
  localparam int unsigned BYTE_FIELD_W = 10;
  localparam int unsigned BIT_FIELD_LSB = 10;
  localparam int unsigned ADDR_FIELD_W = 13;

  // byte offsets of the mapped registers
  localparam int unsigned OFS_STATUS = 'h00;
  localparam int unsigned OFS_ADDR   = 'h04;
  localparam int unsigned OFS_DATA   = 'h08;
  localparam int unsigned OFS_CFG    = 'h0C;
  localparam int unsigned OFS_STRAP  = 'h10;
  localparam int unsigned OFS_CMD    = 'h14;

  // command and data codes
  localparam logic [31:0] CMD_FETCH  = 32'h0000_0002;
  localparam logic [31:0] CMD_ARM    = 32'h0000_0001;
  localparam logic [31:0] CMD_BURN   = 32'hBF79_E5D0;
  localparam logic [31:0] DATA_WIPE  = 32'h0000_0001;
  localparam logic [31:0] CFG_RESET  = 32'h2000_0000;

  // strap copies in the low bytes of the store
  localparam int unsigned STRAP_COPIES = 3;
  localparam int unsigned STRAP_BYTES  = 4 * STRAP_COPIES;

  function automatic logic [31:0] vote3(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [7:0] bit_mask(input logic [2:0] pos);
    return 8'(1) << pos;
  endfunction

  function automatic logic [31:0] status_word(input logic ie, input logic done);
    return {29'b0, ie, done, 1'b1};
  endfunction

endpackage

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq
  import otp_fuse_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_val,
  output logic        fetch_fire,
  output logic        burn_fire
);

  logic armed_q;

  assign fetch_fire = cmd_wr && (cmd_val == CMD_FETCH);
  assign burn_fire  = cmd_wr && (cmd_val == CMD_BURN) && armed_q;

  // only the arm code is retained; any other command write drops it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (cmd_wr) armed_q <= (cmd_val == CMD_ARM);
  end

  AST_UNLOCK_BROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_val != CMD_ARM) |=> !burn_fire); // R7

  AST_FETCH_NOT_BURN: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_fire && burn_fire)); // R5

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
  import otp_fuse_pkg::*;
#(
  parameter int unsigned ARRAY_BYTES = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BYTE_FIELD_W-1:0]  rd_idx,
  output logic [7:0]               rd_byte,
  input  logic                     prog_en,
  input  logic [BYTE_FIELD_W-1:0]  prog_idx,
  input  logic [2:0]               prog_bit,
  output logic [8*STRAP_BYTES-1:0] strap_raw
);

  localparam logic [BYTE_FIELD_W:0] LIMIT = (BYTE_FIELD_W+1)'(ARRAY_BYTES);

  logic [7:0] bytes_w [ARRAY_BYTES];

  for (genvar b = 0; b < ARRAY_BYTES; b++) begin : g_cell
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cell_q <= '0;
      else if (prog_en && prog_idx == BYTE_FIELD_W'(b))
        cell_q <= cell_q | bit_mask(prog_bit);
    end
    assign bytes_w[b] = cell_q;
  end

  for (genvar k = 0; k < STRAP_BYTES; k++) begin : g_strap
    assign strap_raw[8*k +: 8] = bytes_w[k];
  end

  assign rd_byte = ({1'b0, rd_idx} < LIMIT) ? bytes_w[rd_idx] : 8'h00;

  logic       prog_ok;
  logic [7:0] prog_old;
  assign prog_ok  = prog_en && ({1'b0, prog_idx} < LIMIT);
  assign prog_old = bytes_w[prog_idx];

  AST_BURN_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |=> bytes_w[$past(prog_idx)][$past(prog_bit)]); // R6

  AST_NO_FUSE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |=> ((bytes_w[$past(prog_idx)] & $past(prog_old)) == $past(prog_old))); // R8

endmodule

// File: rtl/otp_fuse_vote.sv
module otp_fuse_vote
  import otp_fuse_pkg::*;
(
  input  logic [8*STRAP_BYTES-1:0] strap_raw,
  output logic [31:0]              strap_word
);

  logic [31:0] copy_w [STRAP_COPIES];

  // byte 4*c holds bits 7:0 of copy c (little-endian)
  for (genvar c = 0; c < STRAP_COPIES; c++) begin : g_copy
    assign copy_w[c] = strap_raw[32*c +: 32];
  end

  assign strap_word = vote3(copy_w[0], copy_w[1], copy_w[2]);

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int unsigned ARRAY_BYTES = 1024,
  parameter int unsigned BUS_AW      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);

  localparam int unsigned WORD_W = BUS_AW - 2;

  function automatic logic at_reg(input logic [BUS_AW-1:0] a, input int unsigned ofs);
    return (a[1:0] == 2'b00) && (a[BUS_AW-1:2] == WORD_W'(ofs >> 2));
  endfunction

  logic wr_en, rd_en;
  logic wr_status, wr_addr, wr_data, wr_cfg, wr_cmd;
  assign wr_en     = bus_req && bus_we;
  assign rd_en     = bus_req && !bus_we;
  assign wr_status = wr_en && at_reg(bus_addr, OFS_STATUS);
  assign wr_addr   = wr_en && at_reg(bus_addr, OFS_ADDR);
  assign wr_data   = wr_en && at_reg(bus_addr, OFS_DATA);
  assign wr_cfg    = wr_en && at_reg(bus_addr, OFS_CFG);
  assign wr_cmd    = wr_en && at_reg(bus_addr, OFS_CMD);

  logic                    st_done_q, st_ie_q;
  logic [ADDR_FIELD_W-1:0] addr_q;
  logic [7:0]              data_q;
  logic [31:0]             cfg_q;
  logic                    fetch_fire, burn_fire;
  logic [7:0]              fuse_byte;
  logic [8*STRAP_BYTES-1:0] strap_raw;
  logic [31:0]             strap_word;

  otp_fuse_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (wr_cmd),
    .cmd_val    (bus_wdata),
    .fetch_fire (fetch_fire),
    .burn_fire  (burn_fire)
  );

  otp_fuse_store #(.ARRAY_BYTES(ARRAY_BYTES)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (addr_q[BYTE_FIELD_W-1:0]),
    .rd_byte   (fuse_byte),
    .prog_en   (burn_fire),
    .prog_idx  (addr_q[BYTE_FIELD_W-1:0]),
    .prog_bit  (addr_q[BIT_FIELD_LSB +: 3]),
    .strap_raw (strap_raw)
  );

  otp_fuse_vote vote_i (
    .strap_raw  (strap_raw),
    .strap_word (strap_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done_q <= 1'b0;
      st_ie_q   <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      cfg_q     <= CFG_RESET;
    end else begin
      if (fetch_fire || burn_fire)        st_done_q <= 1'b1;
      else if (wr_status && bus_wdata[1]) st_done_q <= 1'b0;
      if (wr_status) st_ie_q <= bus_wdata[2];
      if (wr_addr)   addr_q  <= bus_wdata[ADDR_FIELD_W-1:0];
      if (fetch_fire)                             data_q <= fuse_byte;
      else if (wr_data && bus_wdata == DATA_WIPE) data_q <= '0;
      if (wr_cfg)    cfg_q   <= bus_wdata;
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (at_reg(bus_addr, OFS_STATUS)) rd_val = status_word(st_ie_q, st_done_q);
    if (at_reg(bus_addr, OFS_ADDR))   rd_val = 32'(addr_q);
    if (at_reg(bus_addr, OFS_DATA))   rd_val = 32'(data_q);
    if (at_reg(bus_addr, OFS_CFG))    rd_val = cfg_q;
    if (at_reg(bus_addr, OFS_STRAP))  rd_val = strap_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_val;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> bus_rvalid); // R2

  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !bus_rvalid); // R2

  AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_fire || burn_fire) |=> st_done_q); // R5

  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && bus_wdata[1]) |=> !st_done_q); // R3

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && bus_wdata != DATA_WIPE) |=> $stable(data_q)); // R9

endmodule

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BURN = 32'hBF79_E5D0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  otp_fuse_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model
  logic [7:0]  m_arr [1024];
  logic        m_done, m_ie, m_armed;
  logic [12:0] m_addr;
  logic [7:0]  m_data;
  logic [31:0] m_cfg;

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) m_arr[i] = 8'h00;
    m_done = 0; m_ie = 0; m_armed = 0; m_addr = '0; m_data = '0;
    m_cfg = 32'h2000_0000;
  endtask

  function automatic logic [31:0] m_strap();
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      int votes = 0;
      for (int c = 0; c < 3; c++) votes += int'(m_arr[4*c + i/8][i%8]);
      r[i] = (votes >= 2);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[11:2])
      10'd0: return {29'b0, m_ie, m_done, 1'b1};
      10'd1: return {19'b0, m_addr};
      10'd2: return {24'b0, m_data};
      10'd3: return m_cfg;
      10'd4: return m_strap();
      default: return '0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    if (a[1:0] != 2'b00) return;
    case (a[11:2])
      10'd0: begin if (d[1]) m_done = 0; m_ie = d[2]; end
      10'd1: m_addr = d[12:0];
      10'd2: if (d == 32'h1) m_data = '0;
      10'd3: m_cfg = d;
      10'd5: begin
        if (d == 32'h2) begin
          m_data = m_arr[m_addr[9:0]]; m_done = 1;
        end else if (d == BURN && m_armed) begin
          m_arr[m_addr[9:0]][m_addr[12:10]] = 1'b1; m_done = 1;
        end
        m_armed = (d == 32'h1);
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    exp = m_read(a);
    @(posedge clk);
    @(negedge clk);
    chk(req, bus_rdata, exp);
    bus_req = 0;
  endtask

  task automatic burn(input int idx, input int pos);
    wr(12'h004, 32'((pos << 10) | idx));
    wr(12'h014, 32'h1);
    wr(12'h014, BURN);
  endtask

  task automatic fetch(input int idx, input string req);
    wr(12'h004, 32'(idx));
    wr(12'h014, 32'h2);
    rd(12'h008, req);
  endtask

  // valid strobe compared with the model every cycle (R2)
  logic exp_rv = 1'b0;
  always @(posedge clk) exp_rv <= rst_n && bus_req && !bus_we;
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (bus_rvalid !== exp_rv) begin
        n_fail++;
        $display("FAIL R2: rvalid actual %0b expected %0b", bus_rvalid, exp_rv);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values
    rd(12'h000, "R1 status"); rd(12'h004, "R1 addr"); rd(12'h008, "R1 data");
    rd(12'h00C, "R1 cfg");    rd(12'h010, "R1 strap"); rd(12'h014, "R1 cmd");
    chk("R1 status literal", m_read(12'h000), 32'h1);

    // R2: unmapped and unaligned reads
    rd(12'h018, "R2 unmapped"); rd(12'hFFC, "R2 top"); rd(12'h00D, "R2 unaligned");

    // R3: status bits
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, "R3 ie set");
    wr(12'h000, 32'h0);         rd(12'h000, "R3 ie clr");

    // R4: address field
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, "R4 mask");

    // R6/R5: burn then fetch, done flag handling
    burn(5, 3);
    rd(12'h000, "R6 done after burn");
    wr(12'h000, 32'h0); rd(12'h000, "R3 done kept on 0");
    wr(12'h000, 32'h2); rd(12'h000, "R3 done w1c");
    fetch(5, "R5 fetch byte5");
    rd(12'h000, "R5 done after fetch");
    chk("R6 byte5 literal", m_read(12'h008), 32'h08);

    // R9: data write rules
    wr(12'h008, 32'h5); rd(12'h008, "R9 ignored");
    wr(12'h008, 32'h1); rd(12'h008, "R9 cleared");

    // R7: broken and missing unlock
    wr(12'h000, 32'h2);
    wr(12'h004, 32'((2 << 10) | 7));
    wr(12'h014, 32'h1); wr(12'h014, 32'h3); wr(12'h014, BURN);
    rd(12'h000, "R7 no done");
    wr(12'h014, BURN);
    rd(12'h000, "R7 lone burn");
    fetch(7, "R7 byte7 untouched");
    wr(12'h000, 32'h2);
    wr(12'h014, 32'h1); wr(12'h014, 32'h2); wr(12'h014, BURN);
    fetch(7, "R7 fetch cancels unlock");

    // R6: interleaved writes keep the unlock; new address used
    wr(12'h014, 32'h1);
    wr(12'h004, 32'((6 << 10) | 9));
    wr(12'h00C, 32'hA5A5_0000);
    wr(12'h014, BURN);
    fetch(9, "R6 interleaved");

    // R8: set-only behaviour
    burn(5, 3); fetch(5, "R8 repeat burn");
    burn(5, 0); fetch(5, "R8 keeps other bits");
    chk("R8 byte5 literal", m_read(12'h008), 32'h09);
    burn(1023, 7); fetch(1023, "R8 last byte");

    // R10: strap vote
    burn(0, 0);
    burn(0, 1); burn(4, 1);
    burn(5, 1); burn(9, 1);
    burn(3, 7); burn(7, 7); burn(11, 7);
    rd(12'h010, "R10 vote");
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, "R10 write ignored");

    // R11: configuration storage
    wr(12'h00C, 32'h1234_5678); rd(12'h00C, "R11 cfg");
    wr(12'h00C, 32'h0);         rd(12'h00C, "R11 cfg zero");

    // R12: unmapped and unaligned writes
    wr(12'h018, 32'hFFFF_FFFF); wr(12'h005, 32'h0); wr(12'h016, 32'h1);
    rd(12'h000, "R12 status"); rd(12'h004, "R12 addr");
    rd(12'h008, "R12 data");   rd(12'h00C, "R12 cfg");
    rd(12'h010, "R12 strap");  rd(12'h014, "R12 cmd reads 0");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule